// File: doc/BRIEF.md
# TLB Invalidate Request Processor

This block decodes one translation-invalidate command at a time and decides what it does to the translation cache. A command carries a 64-bit operand word, a two-bit invalidation-control code, a process-scope flag, a radix flag, a local-only flag, a hypervisor-state bit and a host radix configuration bit. From these the block selects exactly one result. It can raise an illegal-form exception, do nothing, issue a single-page flush with a page-aligned address and a local or broadcast scope, or request a full flush.

Full-flush requests are held in two sticky pending bits, one local and one global. A downstream consumer clears each bit with its own acknowledge. Flushes by process or partition identifier fall back to a full flush, and so do requests that the radix rules leave without a defined meaning. The translation storage itself and any page-walk caching live elsewhere.

Field positions in the operand use big-endian numbering, where bit 0 is the most significant of 64 and LSB-first index i equals 63 minus the big-endian number. The selector (big-endian 52:53) is `cmd_rb[11:10]`, and its values are 0 by address, 1 by process id, 2 by partition id and 3 all. The page-size code (big-endian 56:58) is `cmd_rb[7:5]`. The 12-bit set field (big-endian 40:51) is `cmd_rb[23:12]`. The address quadrant (big-endian 0:1) is `cmd_rb[63:62]`. The page number occupies big-endian 0:51, which is `cmd_rb[63:12]`. Control codes are 0 for translations only, 1 for the walk cache, 2 for everything and 3 for group.

Top module: `tlbinv_proc`

## Requirements
- R1: After reset all result pulses, the flush address and both pending bits are 0. `cmd_ready` is low in reset and is 1 from the first clock after reset is released. A command is taken on any edge where `cmd_valid` and `cmd_ready` are both high.
- R2: Radix mode is `cmd_radix` when `cmd_hv`=1 and `cfg_host_radix` when `cmd_hv`=0. When radix mode is 0, every command is a full flush.
- R3: In radix mode the block raises the exception for any of three forms: control code 3; control code 1 or 2 with selector 0; process-scope 0 with selector 1.
- R4: Control code 1 that is not an invalid form is a no-op (`nop_pulse`). It raises the exception instead when `cmd_local`=1 and the set field `cmd_rb[23:12]` is nonzero.
- R5: A command that is valid in radix mode, has control code 0 or 2, and has a selector other than 0 becomes a full flush.
- R6: Control code 0 with process-scope 1, selector 0 and quadrant `cmd_rb[63:62]` not equal to 00 becomes a full flush.
- R7: Page-size code 0 selects offset mask 0xFFF, 5 selects 0xFFFF, 1 selects 0x1FFFFF and 2 selects 0x3FFFFFFF. Any other code raises the exception on the page-flush path.
- R8: A page flush drives `pflush_addr` = `cmd_rb` with bits 11:0 and the offset-mask bits cleared. `pflush_local` equals `cmd_local`.
- R9: A full flush sets `full_local_pend`. It also sets `full_global_pend` when `cmd_local`=0.
- R10: Each pending bit stays set until its own acknowledge is high on an edge. When a set and an acknowledge meet on the same edge, the bit stays set.
- R11: Each accepted command raises exactly one of `exc_pulse`, `pflush_pulse` and `nop_pulse` for one cycle in the cycle after acceptance, or raises none of them for a full flush. No pulse appears without an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_rb | input | 64 | Operand word (address and fields) |
| cmd_ric | input | 2 | Invalidation-control code |
| cmd_prs | input | 1 | Process-scope flag |
| cmd_radix | input | 1 | Radix flag from the command |
| cmd_local | input | 1 | Local-only scope flag |
| cmd_hv | input | 1 | Issuer is in hypervisor state |
| cfg_host_radix | input | 1 | Host radix configuration bit |
| ack_local | input | 1 | Clears the local pending bit |
| ack_global | input | 1 | Clears the global pending bit |
| exc_pulse | output | 1 | Illegal-form exception pulse |
| pflush_pulse | output | 1 | Single-page flush pulse |
| pflush_addr | output | 64 | Page-aligned flush address |
| pflush_local | output | 1 | Page flush is local (1) or broadcast (0) |
| nop_pulse | output | 1 | Command completed with no effect |
| full_local_pend | output | 1 | Local full flush pending |
| full_global_pend | output | 1 | Global full flush pending |

## Verification
A command is taken on one rising edge. The result pulses, the flush address and scope, and any pending-bit update appear just after that edge, and the pulses drop at the following edge. The bench drives inputs on falling edges and holds a command valid for one falling-to-falling interval. It reads the results at the next falling edge, which sits inside the one-cycle pulse window. It reads again one cycle later to confirm that each pulse lasted one cycle. For pending bits, the acknowledge is driven for one interval, and the bit is read at the falling edge after the clearing edge.

// File: rtl/tlbinv_pkg.sv
// Shared types and constants for the translation-invalidate processor.
// Assumes a big-endian field numbering over a 64-bit operand.
package tlbinv_pkg;

    // Result chosen for one command
    typedef enum logic [1:0] {
        OUT_NOP  = 2'd0,
        OUT_EXC  = 2'd1,
        OUT_PAGE = 2'd2,
        OUT_FULL = 2'd3
    } outcome_e;

    // Invalidation-control codes
    localparam logic [1:0] CTL_XLAT = 2'd0;
    localparam logic [1:0] CTL_WALK = 2'd1;
    localparam logic [1:0] CTL_BOTH = 2'd2;
    localparam logic [1:0] CTL_GRP  = 2'd3;

    // Selector codes
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_PROC = 2'd1;

    // Page-size codes and their offset widths
    localparam int NUM_SIZES = 4;
    localparam logic [2:0] SZ_CODE [NUM_SIZES] = '{3'd0, 3'd5, 3'd1, 3'd2};
    localparam int         SZ_SHIFT[NUM_SIZES] = '{12, 16, 21, 30};

endpackage

// File: rtl/tlbinv_pgmask.sv
// Maps a page-size code to a page-offset mask.
// Assumes XLEN is wide enough for the largest shift; unknown codes give ok=0.
module tlbinv_pgmask
    import tlbinv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]      ap,
    output logic [XLEN-1:0] mask,
    output logic            ok
);
    logic [NUM_SIZES-1:0]  hit;
    logic [XLEN-1:0]       cand [NUM_SIZES];

    // One comparator and constant mask per supported size
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign hit[g]  = (ap == SZ_CODE[g]);
        assign cand[g] = (XLEN'(1) << SZ_SHIFT[g]) - XLEN'(1);
    end

    // Select the mask of the matching size
    always_comb begin
        mask = '0;
        ok   = 1'b0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (hit[i]) begin
                mask = cand[i];
                ok   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlbinv_classify.sv
// Combinational classifier: picks exception, no-op, page flush or full flush
// from the command fields. Assumes fields are already extracted from the operand.
module tlbinv_classify
    import tlbinv_pkg::*;
(
    input  logic [1:0]  ric,
    input  logic        prs,
    input  logic        radix,
    input  logic        hv,
    input  logic        host_radix,
    input  logic        is_local,
    input  logic [1:0]  sel,
    input  logic [11:0] set_f,
    input  logic [1:0]  quad,
    input  logic        ap_ok,
    output outcome_e    kind
);
    logic eff_radix;
    logic bad_form;

    // Effective translation mode comes from the command only in hypervisor state
    assign eff_radix = hv ? radix : host_radix;

    // Forms that are illegal in radix mode
    assign bad_form = (ric == CTL_GRP)
                   || (((ric == CTL_WALK) || (ric == CTL_BOTH)) && (sel == SEL_ADDR))
                   || (!prs && (sel == SEL_PROC));

    // Ordered decision tree
    always_comb begin
        if (!eff_radix) begin
            kind = OUT_FULL;
        end else if (bad_form) begin
            kind = OUT_EXC;
        end else if (ric == CTL_WALK) begin
            kind = (is_local && (set_f != '0)) ? OUT_EXC : OUT_NOP;
        end else if (sel != SEL_ADDR) begin
            kind = OUT_FULL;
        end else if ((ric == CTL_XLAT) && prs && (quad != 2'b00)) begin
            kind = OUT_FULL;
        end else if (!ap_ok) begin
            kind = OUT_EXC;
        end else begin
            kind = OUT_PAGE;
        end
    end
endmodule

// File: rtl/tlbinv_pending.sv
// Sticky pending flags, one per flush scope. A set beats an acknowledge
// on the same edge. Assumes synchronous active-low reset.
module tlbinv_pending #(
    parameter int NPEND = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPEND-1:0] set_i,
    input  logic [NPEND-1:0] ack_i,
    output logic [NPEND-1:0] pend_o
);
    for (genvar g = 0; g < NPEND; g++) begin : g_bit
        // Hold, set or clear one pending flag
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_o[g] <= 1'b0;
            else if (set_i[g])   pend_o[g] <= 1'b1;
            else if (ack_i[g])   pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/tlbinv_proc.sv
// Translation-invalidate request processor. Takes one command per cycle,
// classifies it and reports one registered result the cycle after acceptance.
// Assumes big-endian field numbering over an XLEN-bit operand.
module tlbinv_proc
    import tlbinv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [XLEN-1:0] cmd_rb,
    input  logic [1:0]      cmd_ric,
    input  logic            cmd_prs,
    input  logic            cmd_radix,
    input  logic            cmd_local,
    input  logic            cmd_hv,
    input  logic            cfg_host_radix,
    input  logic            ack_local,
    input  logic            ack_global,
    output logic            exc_pulse,
    output logic            pflush_pulse,
    output logic [XLEN-1:0] pflush_addr,
    output logic            pflush_local,
    output logic            nop_pulse,
    output logic            full_local_pend,
    output logic            full_global_pend
);
    // Big-endian field positions turned into LSB-first indices
    localparam int SEL_LO  = XLEN - 1 - 53;
    localparam int AP_LO   = XLEN - 1 - 58;
    localparam int SET_LO  = XLEN - 1 - 51;
    localparam int EPN_LO  = XLEN - 1 - 51;
    localparam int QUAD_LO = XLEN - 2;
    localparam logic [XLEN-1:0] EPN_MASK = ~((XLEN'(1) << EPN_LO) - XLEN'(1));

    logic            ready_q;
    logic            accept;
    logic [XLEN-1:0] off_mask;
    logic            ap_ok;
    outcome_e        kind;
    logic [XLEN-1:0] page_addr;
    logic [1:0]      pend_set;
    logic [1:0]      pend_q;

    assign cmd_ready = ready_q;
    assign accept    = cmd_valid && ready_q;

    tlbinv_pgmask #(.XLEN(XLEN)) u_pgmask (
        .ap   (cmd_rb[AP_LO +: 3]),
        .mask (off_mask),
        .ok   (ap_ok)
    );

    tlbinv_classify u_classify (
        .ric        (cmd_ric),
        .prs        (cmd_prs),
        .radix      (cmd_radix),
        .hv         (cmd_hv),
        .host_radix (cfg_host_radix),
        .is_local   (cmd_local),
        .sel        (cmd_rb[SEL_LO +: 2]),
        .set_f      (cmd_rb[SET_LO +: 12]),
        .quad       (cmd_rb[QUAD_LO +: 2]),
        .ap_ok      (ap_ok),
        .kind       (kind)
    );

    // Page number kept, offset bits of the chosen size cleared
    assign page_addr = cmd_rb & EPN_MASK & ~off_mask;

    // Full-flush requests: local always, global only for broadcast
    assign pend_set[0] = accept && (kind == OUT_FULL);
    assign pend_set[1] = accept && (kind == OUT_FULL) && !cmd_local;

    tlbinv_pending #(.NPEND(2)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .ack_i  ({ack_global, ack_local}),
        .pend_o (pend_q)
    );

    assign full_local_pend  = pend_q[0];
    assign full_global_pend = pend_q[1];

    // Register the one-cycle result pulses and the page-flush payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q      <= 1'b0;
            exc_pulse    <= 1'b0;
            pflush_pulse <= 1'b0;
            nop_pulse    <= 1'b0;
            pflush_addr  <= '0;
            pflush_local <= 1'b0;
        end else begin
            ready_q      <= 1'b1;
            exc_pulse    <= accept && (kind == OUT_EXC);
            pflush_pulse <= accept && (kind == OUT_PAGE);
            nop_pulse    <= accept && (kind == OUT_NOP);
            if (accept && (kind == OUT_PAGE)) begin
                pflush_addr  <= page_addr;
                pflush_local <= cmd_local;
            end
        end
    end
endmodule

// File: rtl/tlbinv_proc_chk.sv
// Property checker for tlbinv_proc, attached with bind below.
module tlbinv_proc_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            cmd_local,
    input logic            ack_local,
    input logic            ack_global,
    input logic            exc_pulse,
    input logic            pflush_pulse,
    input logic [XLEN-1:0] pflush_addr,
    input logic            pflush_local,
    input logic            nop_pulse,
    input logic            full_local_pend,
    input logic            full_global_pend
);
    assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cmd_ready);

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_pulse, pflush_pulse, nop_pulse}));

    assert_pulse_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_pulse || pflush_pulse || nop_pulse) |-> $past(cmd_valid && cmd_ready));

    assert_addr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pflush_pulse |-> (pflush_addr[11:0] == 12'h000));

    assert_scope_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pflush_pulse |-> (pflush_local == $past(cmd_local)));

    assert_local_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(full_local_pend) && !$past(ack_local)) |-> full_local_pend);

    assert_global_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(full_global_pend) && !$past(ack_global)) |-> full_global_pend);

    assert_global_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_global_pend) |-> $past(cmd_valid && cmd_ready && !cmd_local));
endmodule

bind tlbinv_proc tlbinv_proc_chk #(.XLEN(XLEN)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_valid        (cmd_valid),
    .cmd_ready        (cmd_ready),
    .cmd_local        (cmd_local),
    .ack_local        (ack_local),
    .ack_global       (ack_global),
    .exc_pulse        (exc_pulse),
    .pflush_pulse     (pflush_pulse),
    .pflush_addr      (pflush_addr),
    .pflush_local     (pflush_local),
    .nop_pulse        (nop_pulse),
    .full_local_pend  (full_local_pend),
    .full_global_pend (full_global_pend)
);

// File: tb/tlbinv_proc_tb.sv
// Directed bench for tlbinv_proc: one task per scenario.
module tlbinv_proc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K_NOP = 0, K_EXC = 1, K_PAGE = 2, K_FULL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_rb = '0;
    logic [1:0]  cmd_ric = '0;
    logic        cmd_prs = 1'b0, cmd_radix = 1'b0, cmd_local = 1'b0, cmd_hv = 1'b0;
    logic        cfg_host_radix = 1'b0;
    logic        ack_local = 1'b0, ack_global = 1'b0;
    logic        exc_pulse, pflush_pulse, pflush_local, nop_pulse;
    logic [63:0] pflush_addr;
    logic        full_local_pend, full_global_pend;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] BASE = 64'h0000_1234_5678_9000;

    tlbinv_proc u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rb(cmd_rb), .cmd_ric(cmd_ric), .cmd_prs(cmd_prs), .cmd_radix(cmd_radix),
        .cmd_local(cmd_local), .cmd_hv(cmd_hv), .cfg_host_radix(cfg_host_radix),
        .ack_local(ack_local), .ack_global(ack_global), .exc_pulse(exc_pulse),
        .pflush_pulse(pflush_pulse), .pflush_addr(pflush_addr),
        .pflush_local(pflush_local), .nop_pulse(nop_pulse),
        .full_local_pend(full_local_pend), .full_global_pend(full_global_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Operand builder: sel at [11:10], size code at [7:5], set field at [23:12]
    function automatic logic [63:0] mk_rb(input logic [63:0] base, input logic [1:0] sel,
                                          input logic [2:0] ap, input logic [11:0] setf);
        return base | (64'(setf) << 12) | (64'(sel) << 10) | (64'(ap) << 5);
    endfunction

    // Send one command, check the result window, then clear pending bits
    task automatic send(input string tag, input logic [63:0] rb, input logic [1:0] ric,
                        input logic prs, input logic r, input logic loc, input logic hv,
                        input logic host, input int kind, input logic [63:0] exp_addr,
                        input logic exp_lp, input logic exp_gp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_rb = rb; cmd_ric = ric; cmd_prs = prs; cmd_radix = r;
        cmd_local = loc; cmd_hv = hv; cfg_host_radix = host;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " exc R11"},  64'(exc_pulse),    64'(kind == K_EXC));
        chk({tag, " page R11"}, 64'(pflush_pulse), 64'(kind == K_PAGE));
        chk({tag, " nop R11"},  64'(nop_pulse),    64'(kind == K_NOP));
        if (kind == K_PAGE) begin
            chk({tag, " addr R8"},  pflush_addr,        exp_addr);
            chk({tag, " scope R8"}, 64'(pflush_local),  64'(loc));
        end
        chk({tag, " lpend R9"}, 64'(full_local_pend),  64'(exp_lp));
        chk({tag, " gpend R9"}, 64'(full_global_pend), 64'(exp_gp));
        @(negedge clk);
        chk({tag, " pulse gone R11"}, 64'({exc_pulse, pflush_pulse, nop_pulse}), 64'(0));
        ack_local = 1'b1; ack_global = 1'b1;
        @(negedge clk);
        ack_local = 1'b0; ack_global = 1'b0;
    endtask

    task automatic t_reset();
        chk("reset pulses R1", 64'({exc_pulse, pflush_pulse, nop_pulse}), 64'(0));
        chk("reset pend R1", 64'({full_local_pend, full_global_pend}), 64'(0));
        chk("reset addr R1", pflush_addr, 64'(0));
        chk("ready in reset R1", 64'(cmd_ready), 64'(0));
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("ready after reset R1", 64'(cmd_ready), 64'(1));
    endtask

    task automatic t_page_sizes();
        send("4K R7",  mk_rb(BASE, 2'd0, 3'd0, 12'h0) & ~64'hFFF000 | BASE, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
             K_PAGE, 64'h0000_1234_5678_9000, 1'b0, 1'b0);
        send("64K host R2 R7", mk_rb(BASE, 2'd0, 3'd5, 12'h0) & ~64'hFFF000 | BASE, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
             K_PAGE, 64'h0000_1234_5678_0000, 1'b0, 1'b0);
        send("2M R7",  mk_rb(BASE, 2'd0, 3'd1, 12'h0) & ~64'hFFF000 | BASE, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
             K_PAGE, 64'h0000_1234_5660_0000, 1'b0, 1'b0);
        send("1G R7",  mk_rb(BASE, 2'd0, 3'd2, 12'h0) & ~64'hFFF000 | BASE, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
             K_PAGE, 64'h0000_1234_4000_0000, 1'b0, 1'b0);
        send("bad size R7", mk_rb(BASE, 2'd0, 3'd3, 12'h0) & ~64'hFFF000 | BASE, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
             K_EXC, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic t_nonradix();
        send("hv r=0 R2 R9", mk_rb(BASE, 2'd0, 3'd0, 12'h0), 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
             K_FULL, 64'h0, 1'b1, 1'b1);
        send("host=0 local R2 R9", mk_rb(BASE, 2'd0, 3'd0, 12'h0), 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
             K_FULL, 64'h0, 1'b1, 1'b0);
    endtask

    task automatic t_bad_forms();
        send("ctl3 R3", mk_rb(BASE, 2'd2, 3'd0, 12'h0), 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, K_EXC, 64'h0, 1'b0, 1'b0);
        send("ctl2 sel0 R3", mk_rb(BASE, 2'd0, 3'd0, 12'h0), 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, K_EXC, 64'h0, 1'b0, 1'b0);
        send("ctl1 sel0 R3", mk_rb(BASE, 2'd0, 3'd0, 12'h0), 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, K_EXC, 64'h0, 1'b0, 1'b0);
        send("prs0 sel1 R3", mk_rb(BASE, 2'd1, 3'd0, 12'h0), 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, K_EXC, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic t_walk_cache();
        send("walk bcast set R4", mk_rb(64'h0, 2'd2, 3'd0, 12'h5), 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, K_NOP, 64'h0, 1'b0, 1'b0);
        send("walk local set0 R4", mk_rb(64'h0, 2'd2, 3'd0, 12'h0), 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, K_NOP, 64'h0, 1'b0, 1'b0);
        send("walk local set R4", mk_rb(64'h0, 2'd2, 3'd0, 12'h5), 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, K_EXC, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic t_fallbacks();
        send("sel3 R5", mk_rb(BASE, 2'd3, 3'd0, 12'h0), 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, K_FULL, 64'h0, 1'b1, 1'b1);
        send("ctl2 sel1 R5", mk_rb(BASE, 2'd1, 3'd0, 12'h0), 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, K_FULL, 64'h0, 1'b1, 1'b0);
        send("quad1 R6", mk_rb(64'h4000_0000_0000_0000 | BASE, 2'd0, 3'd0, 12'h0) & ~64'hFFF000 | BASE, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
             K_FULL, 64'h0, 1'b1, 1'b1);
        send("quad0 prs1 R6", mk_rb(BASE, 2'd0, 3'd0, 12'h0), 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
             K_PAGE, 64'h0000_1234_5678_9000, 1'b0, 1'b0);
        send("quad2 prs0 R6", mk_rb(64'h8000_0000_0000_0000 | BASE, 2'd0, 3'd0, 12'h0), 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
             K_PAGE, 64'h8000_1234_5678_9000, 1'b0, 1'b0);
    endtask

    task automatic t_sticky();
        // Broadcast full flush, then acknowledge only the local bit
        @(negedge clk);
        cmd_valid = 1'b1; cmd_ric = 2'd0; cmd_hv = 1'b1; cmd_radix = 1'b0; cmd_local = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("sticky local R10",  64'(full_local_pend),  64'(1));
        chk("sticky global R10", 64'(full_global_pend), 64'(1));
        ack_local = 1'b1;
        @(negedge clk); ack_local = 1'b0;
        chk("ack local only R10",  64'(full_local_pend),  64'(0));
        chk("global kept R10",     64'(full_global_pend), 64'(1));
        ack_global = 1'b1;
        @(negedge clk); ack_global = 1'b0;
        chk("ack global R10", 64'(full_global_pend), 64'(0));
        // Set and acknowledge meet on the same edge: set wins
        cmd_valid = 1'b1; cmd_local = 1'b1; ack_local = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; ack_local = 1'b0;
        chk("set beats ack R10", 64'(full_local_pend), 64'(1));
        ack_local = 1'b1;
        @(negedge clk); ack_local = 1'b0;
        chk("cleared R10", 64'(full_local_pend), 64'(0));
        // Idle inputs produce no pulse
        chk("idle no pulse R11", 64'({exc_pulse, pflush_pulse, nop_pulse}), 64'(0));
    endtask

    initial begin
        fork
            begin
                #1;
                t_reset();
                t_page_sizes();
                t_nonradix();
                t_bad_forms();
                t_walk_cache();
                t_fallbacks();
                t_sticky();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog R11 got=timeout exp=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule